// File: doc/BRIEF.md
# Frame-Number Wall Clock

This block keeps a coarse and a fine count of elapsed time and turns them into a wrapping frame number. A tick counter advances once per clock cycle, which runs at `CLK_RATE` cycles per second. After `CLK_RATE*PPNS` ticks, that is one pulse period of `PPNS` seconds, the tick counter returns to zero and a pulse counter advances. The frame number has `FPS` frames per second and is offset by a programmable reference frame. It is masked to `FRAME_MAX`, which defaults to 1023, so the default is a 10-bit frame number with 10 ms frames.

Software reaches the block through a word-addressed register port with a valid/ready request channel and a valid/ready response channel. A request is accepted when `req_valid && req_ready`. The response appears on the following cycle and is held until `rsp_ready` takes it. While a response is waiting, `req_ready` stays low; this is the only back-pressure the port applies. The register words are:

- word 0: control, with bit 0 the enable
- word 1: pulse count
- word 2: tick-count snapshot
- word 3: tick count
- word 9: base seconds
- word 10: base nanoseconds

A separate command port does one of two things. It can set only the reference frame. Or it can perform a full restart: counting stops, the base time is latched, the reference is stored, the counters are cleared, and counting resumes.

Top module: `wclk_frame_clock`

## Requirements
- R1: After reset there is no response pending, `req_ready` is 1 and `frame_valid` is 0. The control word (word 0) and the tick count (word 3) both read 0.
- R2: While enable (word 0 bit 0) is 1, the tick count rises by one each cycle. In the cycle after it reaches `CLK_RATE*PPNS-1` it returns to 0 and the pulse count rises by one.
- R3: While enable is 0, the pulse count and the tick count hold their values.
- R4: A write of 1 to enable while enable is 0 clears the pulse count, the tick count and the snapshot at the accepting edge. A write of 1 while enable is already 1 clears nothing.
- R5: A write to the tick count (word 3) loads the same value into the snapshot (word 2). A read of the pulse count (word 1) returns the pulse count as it stood at the accepting edge. The same read copies the tick count of that edge into the snapshot, including when the pulse count rolls over at that very edge.
- R6: A write to the snapshot answers with `rsp_err`=1 and leaves the snapshot unchanged. Any offset other than 0, 1, 2, 3, 9 and 10 answers with `rsp_err`=1 and `rsp_rdata`=0. Words 9 and 10 are readable and writable.
- R7: `frame_num` = (FPS·PPNS·pulse + ⌊tick·FPS/CLK_RATE⌋ + reference) & FRAME_MAX.
- R8: A command whose `set_ref` exceeds `FRAME_MAX` is refused, whether it is a reference-only or a full command. `set_reject` is 1 on the next cycle, and the stored reference, the counters and enable are unchanged.
- R9: An accepted full command (`set_req`=1, `set_ref_only`=0) does all of the following at one edge:
  - zeroes the counters and the snapshot;
  - sets enable to 1;
  - stores the reference;
  - loads word 9 with `now_sec` − 315964800 (modulo 2^32);
  - loads word 10 with `now_nsec`.
- R10: `frame_valid` is 1 exactly when enable is 1 and a reference has been accepted since reset.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_rdata` and `rsp_err` hold steady and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_RATE` cycles per second |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| set_req | input | 1 | Frame command strobe |
| set_ref_only | input | 1 | 1 = store reference only, 0 = full restart |
| set_ref | input | 16 | Requested reference frame |
| now_sec | input | 32 | External seconds value for the base time |
| now_nsec | input | 32 | External nanoseconds value for the base time |
| set_reject | output | 1 | Previous cycle's command was refused |
| frame_num | output | 10 | Current frame number |
| frame_valid | output | 1 | Frame number is meaningful |

## Verification
The collision that matters is a pulse-count read accepted on the very edge where the tick count rolls over and the pulse count advances. The bench provokes it by loading the tick count to five below the wrap point and then waiting exactly until the read lands on the last tick. It judges the result in three steps:
- the read must return the old pulse count;
- the snapshot must then read the last tick value, not zero;
- later reads must show the new pulse count and a tick count that restarted from zero.

A second collision is a response being held under back-pressure while the counters keep moving. This one is judged by the held response data staying frozen.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

  localparam int unsigned ADDR_W = 4;

  // Register word offsets; software decodes these positions.
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PULSE = 4'd1;
  localparam logic [ADDR_W-1:0] A_SNAP  = 4'd2;
  localparam logic [ADDR_W-1:0] A_TICKS = 4'd3;
  localparam logic [ADDR_W-1:0] A_BSEC  = 4'd9;
  localparam logic [ADDR_W-1:0] A_BNS   = 4'd10;

  // Seconds between the two epochs used for the base timestamp.
  localparam logic [31:0] EPOCH_SHIFT = 32'd315964800;

endpackage

// File: rtl/wclk_tick_counter.sv
module wclk_tick_counter #(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned TICKS_PER_PULSE = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic              ld_pulse,
  input  logic              ld_ticks,
  input  logic [DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0] pulse_cnt,
  output logic [DATA_W-1:0] tick_cnt
);

  localparam logic [DATA_W-1:0] LAST = DATA_W'(TICKS_PER_PULSE - 1);

  logic at_wrap;
  assign at_wrap = (tick_cnt >= LAST);

  // Priority: clear, then bus load, then counting.
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tick_cnt  <= '0;
      pulse_cnt <= '0;
    end else begin
      if (ld_ticks)
        tick_cnt <= ld_val;
      else if (run)
        tick_cnt <= at_wrap ? '0 : tick_cnt + 1'b1;

      if (ld_pulse)
        pulse_cnt <= ld_val;
      else if (run && !ld_ticks && at_wrap)
        pulse_cnt <= pulse_cnt + 1'b1;
    end
  end

  // R2: one tick per enabled cycle below the wrap point
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !ld_ticks && tick_cnt < LAST)
      |=> tick_cnt == $past(tick_cnt) + 1'b1);

  // R2: rollover feeds the pulse counter
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !ld_ticks && !ld_pulse && tick_cnt == LAST)
      |=> (tick_cnt == '0) && (pulse_cnt == $past(pulse_cnt) + 1'b1));

  // R3: disabled counters hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear && !ld_ticks && !ld_pulse)
      |=> $stable(tick_cnt) && $stable(pulse_cnt));

endmodule

// File: rtl/wclk_frame.sv
module wclk_frame #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CLK_RATE  = 1000,
  parameter int unsigned PPNS      = 2,
  parameter int unsigned FPS       = 100,
  parameter int unsigned FRAME_MAX = 1023,
  parameter int unsigned REF_W     = 16,
  parameter int unsigned FRAME_W   = $clog2(FRAME_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_req,
  input  logic               set_ref_only,
  input  logic [REF_W-1:0]   set_ref,
  input  logic [DATA_W-1:0]  pulse_cnt,
  input  logic [DATA_W-1:0]  tick_cnt,
  input  logic               run,
  output logic               set_go,
  output logic               set_reject,
  output logic [FRAME_W-1:0] frame_num,
  output logic               frame_valid
);

  localparam int unsigned WIDE_W = DATA_W + 8;
  localparam logic [WIDE_W-1:0] PULSE_FRAMES = WIDE_W'(FPS * PPNS);
  localparam logic [WIDE_W-1:0] FPS_W        = WIDE_W'(FPS);
  localparam logic [WIDE_W-1:0] RATE_W       = WIDE_W'(CLK_RATE);
  localparam logic [FRAME_W-1:0] MASK        = FRAME_W'(FRAME_MAX);

  logic               ref_ok;
  logic [FRAME_W-1:0] ref_q;
  logic               ref_set_q;
  logic [WIDE_W-1:0]  coarse, fine, wide;
  logic [WIDE_W-FRAME_W-1:0] unused_wide_hi;

  assign ref_ok = (32'(set_ref) <= 32'(FRAME_MAX));
  assign set_go = set_req && !set_ref_only && ref_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q      <= '0;
      ref_set_q  <= 1'b0;
      set_reject <= 1'b0;
    end else begin
      set_reject <= set_req && !ref_ok;
      if (set_req && ref_ok) begin
        ref_q     <= set_ref[FRAME_W-1:0];
        ref_set_q <= 1'b1;
      end
    end
  end

  // Frame arithmetic: whole pulses, fraction of the current pulse, offset.
  assign coarse = WIDE_W'(pulse_cnt) * PULSE_FRAMES;
  assign fine   = (WIDE_W'(tick_cnt) * FPS_W) / RATE_W;
  assign wide   = coarse + fine + WIDE_W'(ref_q);
  assign unused_wide_hi = wide[WIDE_W-1:FRAME_W];

  assign frame_num   = wide[FRAME_W-1:0] & MASK;
  assign frame_valid = run && ref_set_q;

  // R8: an out-of-range reference never reaches storage
  a_r8_reject_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !ref_ok) |=> $stable(ref_q) && set_reject);

endmodule

// File: rtl/wclk_regs.sv
module wclk_regs
  import wclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] pulse_cnt,
  input  logic [DATA_W-1:0] tick_cnt,
  input  logic              set_go,
  input  logic [DATA_W-1:0] set_sec,
  input  logic [DATA_W-1:0] set_nsec,
  output logic              run,
  output logic              clear,
  output logic              ld_pulse,
  output logic              ld_ticks
);

  logic [DATA_W-1:0] ctrl_q, snap_q, bsec_q, bns_q, rd_mux;
  logic accept, wr, rd, known, bad, wr_ctrl;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write;
  assign rd        = accept && !req_write;

  always_comb begin
    known  = 1'b1;
    rd_mux = '0;
    case (req_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_PULSE: rd_mux = pulse_cnt;
      A_SNAP:  rd_mux = snap_q;
      A_TICKS: rd_mux = tick_cnt;
      A_BSEC:  rd_mux = bsec_q;
      A_BNS:   rd_mux = bns_q;
      default: known  = 1'b0;
    endcase
  end

  assign bad      = !known || (req_write && req_addr == A_SNAP);
  assign wr_ctrl  = wr && (req_addr == A_CTRL) && !set_go;
  assign clear    = set_go || (wr_ctrl && req_wdata[0] && !ctrl_q[0]);
  assign ld_ticks = wr && (req_addr == A_TICKS) && !set_go;
  assign ld_pulse = wr && (req_addr == A_PULSE) && !set_go;
  assign run      = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      snap_q <= '0;
      bsec_q <= '0;
      bns_q  <= '0;
    end else begin
      if (set_go)
        ctrl_q <= ctrl_q | DATA_W'(1);
      else if (wr_ctrl)
        ctrl_q <= req_wdata;

      if (clear)
        snap_q <= '0;
      else if (ld_ticks)
        snap_q <= req_wdata;
      else if (rd && req_addr == A_PULSE)
        snap_q <= tick_cnt;

      if (set_go) begin
        bsec_q <= set_sec;
        bns_q  <= set_nsec;
      end else begin
        if (wr && req_addr == A_BSEC) bsec_q <= req_wdata;
        if (wr && req_addr == A_BNS)  bns_q  <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= bad;
      rsp_rdata <= (req_write || bad) ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11: a waiting response does not move
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R6: refused accesses carry no data
  a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == '0);

  // R5: tick-count write mirrors into the snapshot
  a_r5_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ticks |=> snap_q == $past(req_wdata));

endmodule

// File: rtl/wclk_frame_clock.sv
module wclk_frame_clock
  import wclk_pkg::*;
#(
  parameter int unsigned CLK_RATE  = 1000,
  parameter int unsigned PPNS      = 2,
  parameter int unsigned FPS       = 100,
  parameter int unsigned FRAME_MAX = 1023,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REF_W     = 16,
  parameter int unsigned FRAME_W   = $clog2(FRAME_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               set_req,
  input  logic               set_ref_only,
  input  logic [REF_W-1:0]   set_ref,
  input  logic [DATA_W-1:0]  now_sec,
  input  logic [DATA_W-1:0]  now_nsec,
  output logic               set_reject,
  output logic [FRAME_W-1:0] frame_num,
  output logic               frame_valid
);

  localparam int unsigned TICKS_PER_PULSE = CLK_RATE * PPNS;

  logic              run, clear, ld_pulse, ld_ticks, set_go;
  logic [DATA_W-1:0] pulse_cnt, tick_cnt, base_sec;

  assign base_sec = now_sec - DATA_W'(EPOCH_SHIFT);

  wclk_tick_counter #(
    .DATA_W          (DATA_W),
    .TICKS_PER_PULSE (TICKS_PER_PULSE)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clear     (clear),
    .ld_pulse  (ld_pulse),
    .ld_ticks  (ld_ticks),
    .ld_val    (req_wdata),
    .pulse_cnt (pulse_cnt),
    .tick_cnt  (tick_cnt)
  );

  wclk_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .pulse_cnt (pulse_cnt),
    .tick_cnt  (tick_cnt),
    .set_go    (set_go),
    .set_sec   (base_sec),
    .set_nsec  (now_nsec),
    .run       (run),
    .clear     (clear),
    .ld_pulse  (ld_pulse),
    .ld_ticks  (ld_ticks)
  );

  wclk_frame #(
    .DATA_W    (DATA_W),
    .CLK_RATE  (CLK_RATE),
    .PPNS      (PPNS),
    .FPS       (FPS),
    .FRAME_MAX (FRAME_MAX),
    .REF_W     (REF_W),
    .FRAME_W   (FRAME_W)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_req      (set_req),
    .set_ref_only (set_ref_only),
    .set_ref      (set_ref),
    .pulse_cnt    (pulse_cnt),
    .tick_cnt     (tick_cnt),
    .run          (run),
    .set_go       (set_go),
    .set_reject   (set_reject),
    .frame_num    (frame_num),
    .frame_valid  (frame_valid)
  );

  // R9: a full command restarts counting from zero
  a_r9_set_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    set_go |=> (tick_cnt == '0) && (pulse_cnt == '0) && run);

endmodule

// File: tb/tb_wclk_frame_clock.sv
module tb_wclk_frame_clock;

  localparam int CR  = 200;
  localparam int PP  = 3;
  localparam int TPP = CR * PP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        set_req = 1'b0, set_ref_only = 1'b0;
  logic [15:0] set_ref = '0;
  logic [31:0] now_sec = '0, now_nsec = '0;
  logic        set_reject, frame_valid;
  logic [9:0]  frame_num;

  wclk_frame_clock #(.CLK_RATE(CR), .PPNS(PP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata),
    .set_req(set_req), .set_ref_only(set_ref_only), .set_ref(set_ref),
    .now_sec(now_sec), .now_nsec(now_nsec), .set_reject(set_reject),
    .frame_num(frame_num), .frame_valid(frame_valid)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0, n_fail = 0;
  int   ticks = 0;
  bit   en_m = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fexp(input int t, input int r);
    return ((t / TPP) * PP * 100 + ((t % TPP) * 100) / CR + r) & 1023;
  endfunction

  // Monitor: pop and compare each response as it is handed over
  always @(negedge clk) begin : mon
    exp_t x;
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) chk(1'b0, "R11 spurious response", rsp_rdata, 0);
      else begin
        x = sb.pop_front();
        chk(rsp_rdata == x.d && rsp_err == x.e, x.tag,
            {rsp_err, rsp_rdata}, {x.e, x.d});
      end
    end
  end

  // Driver: push the expectation, present the request for one cycle
  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] exp_d, input bit exp_e, input string tag);
    exp_t x;
    x.d = exp_d; x.e = exp_e; x.tag = tag;
    sb.push_back(x);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp_d, input string tag);
    bus(1'b0, a, '0, exp_d, 1'b0, tag);
    if (en_m) ticks++;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (en_m) ticks++;
    end
  endtask

  task automatic cmd(input bit only, input int r, input logic [31:0] s, input logic [31:0] ns);
    set_req = 1'b1; set_ref_only = only; set_ref = 16'(r); now_sec = s; now_nsec = ns;
    @(negedge clk);
    set_req = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(frame_valid == 1'b0, "R1 frame_valid", frame_valid, 0);
    rd(4'd0, 32'd0, "R1 ctrl reads 0");
    rd(4'd3, 32'd0, "R1 ticks read 0");

    // R4 enable rise, R2 counting
    bus(1'b1, 4'd0, 32'd1, 32'd0, 1'b0, "R4 enable write");
    ticks = 0; en_m = 1'b1;
    step(10);
    rd(4'd3, 32'(ticks % TPP), "R2 ticks after 10 cycles");
    rd(4'd1, 32'd0, "R2 pulse still 0");
    rd(4'd2, 32'd11, "R5 snapshot from pulse read");
    chk(frame_valid == 1'b0, "R10 no reference yet", frame_valid, 0);

    // R5 tick write and read on the rollover edge
    bus(1'b1, 4'd3, 32'd595, 32'd0, 1'b0, "R5 ticks write");
    ticks = (ticks / TPP) * TPP + 595;
    rd(4'd2, 32'd595, "R5 snapshot mirrors tick write");
    step(TPP - 1 - ticks);
    rd(4'd1, 32'd0, "R5 pulse read at rollover edge");
    rd(4'd2, 32'(TPP - 1), "R5 snapshot holds last tick");
    rd(4'd1, 32'd1, "R2 pulse advanced");
    rd(4'd3, 32'(ticks % TPP), "R2 ticks restarted");

    // R8 / R10 reference handling
    cmd(1'b1, 2000, '0, '0); ticks++;
    chk(set_reject == 1'b1, "R8 reject flag", set_reject, 1);
    chk(frame_valid == 1'b0, "R10 refused ref does not validate", frame_valid, 0);
    cmd(1'b1, 5, '0, '0); ticks++;
    chk(set_reject == 1'b0, "R8 accepted ref no reject", set_reject, 0);
    chk(frame_valid == 1'b1, "R10 valid after ref", frame_valid, 1);
    chk(frame_num == fexp(ticks, 5), "R7 frame after ref", frame_num, fexp(ticks, 5));
    cmd(1'b1, 1500, '0, '0); ticks++;
    chk(frame_num == fexp(ticks, 5), "R8 ref unchanged", frame_num, fexp(ticks, 5));
    step(900);
    chk(frame_num == fexp(ticks, 5), "R7 frame later", frame_num, fexp(ticks, 5));

    // R3 disable holds
    bus(1'b1, 4'd0, 32'd0, 32'd0, 1'b0, "R3 disable write");
    ticks++; en_m = 1'b0;
    chk(frame_valid == 1'b0, "R10 invalid when disabled", frame_valid, 0);
    step(20);
    rd(4'd3, 32'(ticks % TPP), "R3 ticks held");
    rd(4'd1, 32'(ticks / TPP), "R3 pulse held");

    // R4 rise clears, repeated 1 does not
    bus(1'b1, 4'd0, 32'd1, 32'd0, 1'b0, "R4 re-enable");
    ticks = 0; en_m = 1'b1;
    rd(4'd3, 32'd0, "R4 ticks cleared");
    bus(1'b1, 4'd0, 32'd1, 32'd0, 1'b0, "R4 enable again");
    ticks++;
    rd(4'd3, 32'(ticks), "R4 no clear while enabled");

    // R6 refused and undefined accesses
    bus(1'b1, 4'd2, 32'd77, 32'd0, 1'b1, "R6 snapshot write refused"); ticks++;
    rd(4'd2, 32'd0, "R6 snapshot unchanged");
    bus(1'b1, 4'd5, 32'd9, 32'd0, 1'b1, "R6 write to hole"); ticks++;
    bus(1'b0, 4'd15, 32'd0, 32'd0, 1'b1, "R6 read of hole"); ticks++;
    bus(1'b1, 4'd9, 32'h1234, 32'd0, 1'b0, "R6 base write"); ticks++;
    rd(4'd9, 32'h1234, "R6 base readback");

    // R9 full restart
    cmd(1'b0, 700, 32'd1400000000, 32'd123456789);
    ticks = 0; en_m = 1'b1;
    rd(4'd9, 32'd1400000000 - 32'd315964800, "R9 base seconds");
    rd(4'd10, 32'd123456789, "R9 base nanoseconds");
    rd(4'd3, 32'(ticks), "R9 ticks restarted");
    rd(4'd0, 32'd1, "R9 enable set");
    chk(frame_num == fexp(ticks, 700), "R9 frame with new ref", frame_num, fexp(ticks, 700));
    step(2400);
    chk(frame_num == fexp(ticks, 700), "R7 frame masked", frame_num, fexp(ticks, 700));
    cmd(1'b0, 1100, 32'd5, 32'd5); ticks++;
    chk(set_reject == 1'b1, "R8 full command refused", set_reject, 1);
    chk(frame_num == fexp(ticks, 700), "R8 no restart", frame_num, fexp(ticks, 700));

    // R11 back-pressure
    rsp_ready = 1'b0;
    rd(4'd0, 32'd1, "R11 held response data");
    chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R11 stall visible", req_ready, 0);
    step(3);
    chk(rsp_valid == 1'b1 && rsp_rdata == 32'd1, "R11 response held", rsp_rdata, 1);
    chk(req_ready == 1'b0, "R11 req_ready low", req_ready, 0);
    rsp_ready = 1'b1;
    step(2);
    chk(rsp_valid == 1'b0, "R11 response drained", rsp_valid, 0);

    step(3);
    if (sb.size() != 0) chk(1'b0, "R11 missing responses", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule